// File: doc/BRIEF.md
# Half-Bridge Interlock and Deadtime Generator

This block turns two gate commands for a half-bridge into two gate-enable outputs. The high-side command is active high and the low-side command is active low. The block never lets both sides conduct at once. A command that asks for both sides at the same time switches both outputs off; it does not pick one side over the other. Every turn-on is held back by a programmable deadtime, counted in clock cycles, before the output rises.

An active-high run enable comes from the shutdown logic and an undervoltage flag comes from supply supervision. Either one forces both outputs low at once. A turn-off reaches the output in the same cycle as its cause, because each output is gated by the live request. A turn-on is registered and waits out the deadtime. The deadtime count is sampled when each waiting interval starts. A count of zero is treated as one cycle, so some deadtime is always present. The same counter serves both hand-off directions, so the deadtime is the same for low-to-high and high-to-low hand-offs.

Top module: `hb_deadtime_gen`

## Requirements
- R1: `loGate` may be high only while `loCmdN` is 0 (active low). `hiGate` may be high only while `hiCmd` is 1 (active high). After reset both outputs are 0.
- R2: While `runEn` is 0, both outputs are 0 in the same cycle, whatever the commands are.
- R3: With `runEn`=1, `hiCmd`=0 and `loCmdN`=1 (no side requested), both outputs are 0.
- R4: With `runEn`=1, `hiCmd`=1 and `loCmdN`=0 (both sides requested), both outputs are 0 for as long as the condition lasts. `hiGate` and `loGate` are never 1 together.
- R5: Let a side's request first be sampled at clock edge k, with the opposite output already 0. The output of that side rises after edge k+D, where D = max(`dtCycles`, 1), and it stays high while the request holds.
- R6: A turn-on never happens in the cycle right after the opposite output was high.
- R7: The delay D applies equally to a turn-on from idle, a low-to-high hand-off and a high-to-low hand-off. A `dtCycles` of 0 gives a deadtime of one cycle.
- R8: An output falls in the same cycle as the input change that removes its request: its own command, the opposite command, `runEn` or `uvFault`.
- R9: If a request is withdrawn before its output has risen, the pending turn-on is cancelled. A later request waits a full D again, counted from its own first sampled edge.
- R10: `dtCycles` is sampled at the edge that starts a waiting interval. Changing it during the wait does not alter that wait.
- R11: While `uvFault` is 1, both outputs are 0 and any wait is reset. After `uvFault` clears, a held request waits a full D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hiCmd | input | 1 | High-side command, active high |
| loCmdN | input | 1 | Low-side command, active low |
| runEn | input | 1 | Run enable from shutdown logic; 0 forces both outputs off |
| uvFault | input | 1 | Undervoltage flag; 1 forces both outputs off and resets the wait |
| dtCycles | input | DT_W | Deadtime in clock cycles, 0 treated as 1 |
| hiGate | output | 1 | High-side gate enable |
| loGate | output | 1 | Low-side gate enable |

## Verification
The assertions check on every cycle the properties that hold in all cases:
- the outputs are never both high;
- each output obeys its command polarity;
- the outputs are forced low under shutdown and undervoltage;
- a rising output comes only after the opposite side was low and the request was already present in the cycle before.

The exact length of the deadtime is shown only by the bench's sweeps. These sweeps cover the count being taken once per interval, the cancellation of a withdrawn request, and the equal timing of both hand-off directions. The bench counts the edges to each rise and compares the count with max(`dtCycles`, 1).

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_ON_HI,
    ST_ON_LO
  } dtState_t;

  // strobes from control to the deadtime datapath
  typedef struct packed {
    logic clear;  // drop any wait in progress
    logic load;   // start a new wait, capture the count
    logic inc;    // one more cycle waited
  } dtStrobe_t;

endpackage

// File: rtl/hb_dt_counter.sv
module hb_dt_counter
  import hb_dt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dtStrobe_t       strb,
  input  logic [DT_W-1:0] dtCycles,
  output logic            expired
);

  localparam logic [DT_W-1:0] MIN_DT = DT_W'(1);

  logic [DT_W-1:0] waitCnt;
  logic [DT_W-1:0] dtHeld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitCnt <= '0;
      dtHeld  <= MIN_DT;
    end else if (strb.clear) begin
      waitCnt <= '0;
    end else if (strb.load) begin
      waitCnt <= '0;
      dtHeld  <= (dtCycles == '0) ? MIN_DT : dtCycles;
    end else if (strb.inc) begin
      waitCnt <= waitCnt + DT_W'(1);
    end
  end

  // the cycle being waited now is the last one of the interval
  assign expired = ({1'b0, waitCnt} + (DT_W+1)'(1)) >= {1'b0, dtHeld};

endmodule

// File: rtl/hb_dt_ctrl.sv
module hb_dt_ctrl
  import hb_dt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqHi,
  input  logic      reqLo,
  input  logic      expired,
  output dtStrobe_t strb,
  output logic      hiOn,
  output logic      loOn
);

  dtState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (reqHi) begin
      unique case (state)
        ST_ON_HI:   nextState = ST_ON_HI;
        ST_WAIT_HI: begin
          if (expired) nextState = ST_ON_HI;
          else         strb.inc = 1'b1;
        end
        default: begin
          nextState = ST_WAIT_HI;
          strb.load = 1'b1;
        end
      endcase
    end else if (reqLo) begin
      unique case (state)
        ST_ON_LO:   nextState = ST_ON_LO;
        ST_WAIT_LO: begin
          if (expired) nextState = ST_ON_LO;
          else         strb.inc = 1'b1;
        end
        default: begin
          nextState = ST_WAIT_LO;
          strb.load = 1'b1;
        end
      endcase
    end else begin
      nextState  = ST_IDLE;
      strb.clear = 1'b1;
    end
  end

  assign hiOn = (state == ST_ON_HI);
  assign loOn = (state == ST_ON_LO);

endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen
  import hb_dt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hiCmd,
  input  logic            loCmdN,
  input  logic            runEn,
  input  logic            uvFault,
  input  logic [DT_W-1:0] dtCycles,
  output logic            hiGate,
  output logic            loGate
);

  logic      allowed;
  logic      reqHi;
  logic      reqLo;
  logic      expired;
  logic      hiOn;
  logic      loOn;
  dtStrobe_t strb;

  // a request for both sides counts as a request for neither
  assign allowed = runEn & ~uvFault;
  assign reqHi   = allowed &  hiCmd &  loCmdN;
  assign reqLo   = allowed & ~loCmdN & ~hiCmd;

  hb_dt_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqHi   (reqHi),
    .reqLo   (reqLo),
    .expired (expired),
    .strb    (strb),
    .hiOn    (hiOn),
    .loOn    (loOn)
  );

  hb_dt_counter #(.DT_W(DT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .dtCycles (dtCycles),
    .expired  (expired)
  );

  // turn-off follows the live request, turn-on waits for the state
  assign hiGate = hiOn & reqHi;
  assign loGate = loOn & reqLo;

endmodule

// File: rtl/hb_deadtime_gen_chk.sv
module hb_deadtime_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic hiCmd,
  input logic loCmdN,
  input logic runEn,
  input logic uvFault,
  input logic hiGate,
  input logic loGate
);

  p_polarity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (loGate |-> !loCmdN) and (hiGate |-> hiCmd));

  p_shutdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |-> (!hiGate && !loGate));

  p_never_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hiGate && loGate));

  p_both_cmd_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hiCmd && !loCmdN) |-> (!hiGate && !loGate));

  p_gap_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiGate) |-> !$past(loGate));

  p_gap_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loGate) |-> !$past(hiGate));

  p_min_dt_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiGate) |-> $past(hiCmd && loCmdN && runEn && !uvFault));

  p_min_dt_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loGate) |-> $past(!hiCmd && !loCmdN && runEn && !uvFault));

  p_uv_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uvFault |-> (!hiGate && !loGate));

endmodule

bind hb_deadtime_gen hb_deadtime_gen_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .hiCmd   (hiCmd),
  .loCmdN  (loCmdN),
  .runEn   (runEn),
  .uvFault (uvFault),
  .hiGate  (hiGate),
  .loGate  (loGate)
);

// File: tb/hb_deadtime_gen_tb.sv
module hb_deadtime_gen_tb_top;

  localparam int DT_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            hiCmd;
  logic            loCmdN;
  logic            runEn;
  logic            uvFault;
  logic [DT_W-1:0] dtCycles;
  logic            hiGate;
  logic            loGate;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  hb_deadtime_gen #(.DT_W(DT_W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hiCmd    (hiCmd),
    .loCmdN   (loCmdN),
    .runEn    (runEn),
    .uvFault  (uvFault),
    .dtCycles (dtCycles),
    .hiGate   (hiGate),
    .loGate   (loGate)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int effDt(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  // hi=1: request high side, hi=0: request low side
  task automatic setSide(input bit hi);
    hiCmd  = hi;
    loCmdN = hi;
  endtask

  task automatic setIdle();
    hiCmd  = 1'b0;
    loCmdN = 1'b1;
  endtask

  // request was applied at this negedge; count edges to the rise
  task automatic expectRise(input bit hi, input int d, input string req);
    for (int seen = 1; seen <= effDt(d) + 2; seen++) begin
      cyc();
      chk(req, $sformatf("gate seen=%0d d=%0d hi=%0b", seen, d, hi),
          hi ? hiGate : loGate, (seen >= effDt(d) + 1));
      chk(req, "opposite gate", hi ? loGate : hiGate, 1'b0);
    end
  endtask

  task automatic turnOn(input bit hi, input int d, input string req);
    dtCycles = DT_W'(d);
    setSide(hi);
    #1;
    chk("R8", "opposite drops at once", hi ? loGate : hiGate, 1'b0);
    chk(req, "no instant turn-on", hi ? hiGate : loGate, 1'b0);
    @(negedge clk);
    // first edge samples the request: restart the count from here
    setIdle();
    cyc();
    setSide(hi);
    expectRise(hi, d, req);
  endtask

  initial begin
    rst_n    = 1'b0;
    hiCmd    = 1'b0;
    loCmdN   = 1'b1;
    runEn    = 1'b1;
    uvFault  = 1'b0;
    dtCycles = DT_W'(3);
    repeat (3) @(negedge clk);
    chk("R1", "reset hiGate", hiGate, 1'b0);
    chk("R1", "reset loGate", loGate, 1'b0);
    rst_n = 1'b1;
    cyc();

    // R3 idle
    setIdle();
    repeat (4) cyc();
    chk("R3", "idle hiGate", hiGate, 1'b0);
    chk("R3", "idle loGate", loGate, 1'b0);

    // R4 both requested
    hiCmd  = 1'b1;
    loCmdN = 1'b0;
    for (int i = 0; i < 10; i++) begin
      cyc();
      chk("R4", "both cmd hiGate", hiGate, 1'b0);
      chk("R4", "both cmd loGate", loGate, 1'b0);
    end

    // R2 shutdown over all command patterns, starting with low side on
    setIdle();
    cyc();
    turnOn(1'b0, 2, "R5");
    runEn = 1'b0;
    #1;
    chk("R2", "shutdown drops loGate at once", loGate, 1'b0);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      hiCmd  = p[0];
      loCmdN = p[1];
      repeat (3) cyc();
      chk("R2", $sformatf("shutdown hiGate p=%0d", p), hiGate, 1'b0);
      chk("R2", $sformatf("shutdown loGate p=%0d", p), loGate, 1'b0);
    end
    runEn = 1'b1;
    setIdle();
    cyc();

    // R5/R7 deadtime sweep: from idle and both hand-off directions
    for (int d = 0; d <= 6; d++) begin
      setIdle();
      repeat (2) cyc();
      turnOn(1'b1, d, "R5");
      turnOn(1'b0, d, "R7");
      turnOn(1'b1, d, "R7");
    end
    setIdle();
    cyc();
    turnOn(1'b0, 255, "R5");

    // R8 own command withdrawn: immediate fall
    setIdle();
    #1;
    chk("R8", "loGate falls with own command", loGate, 1'b0);
    cyc();

    // R9 cancel: partial wait, withdraw, then full wait again
    dtCycles = DT_W'(5);
    setSide(1'b1);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R9", "partial wait hiGate", hiGate, 1'b0);
    end
    setIdle();
    cyc();
    setSide(1'b1);
    expectRise(1'b1, 5, "R9");
    // switch mid-wait to the other side restarts the count
    setIdle();
    cyc();
    setSide(1'b0);
    repeat (2) cyc();
    setSide(1'b1);
    expectRise(1'b1, 5, "R9");

    // R10 count captured at start of interval
    setIdle();
    cyc();
    dtCycles = DT_W'(4);
    setSide(1'b1);
    cyc();
    dtCycles = DT_W'(1);
    chk("R10", "hiGate after first edge", hiGate, 1'b0);
    for (int seen = 2; seen <= 6; seen++) begin
      cyc();
      chk("R10", $sformatf("hiGate seen=%0d", seen), hiGate, (seen >= 5));
    end

    // R11 undervoltage
    uvFault = 1'b1;
    #1;
    chk("R11", "uv drops hiGate at once", hiGate, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R11", "uv hold hiGate", hiGate, 1'b0);
      chk("R11", "uv hold loGate", loGate, 1'b0);
    end
    dtCycles = DT_W'(3);
    uvFault  = 1'b0;
    expectRise(1'b1, 3, "R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule